// File: doc/BRIEF.md
# Ping-pong descriptor sequencer

This block decides which of a DMA channel's two descriptors, primary or alternate, the address generator works on, and when it may move a unit of data. Software picks a cycle type and starts the channel on one descriptor. In basic mode every arbitration unit waits for its own peripheral request. In auto-request mode one request releases the whole descriptor. In ping-pong mode each finished descriptor hands over to the other one, so software can refill one buffer while the other drains.

Each time a descriptor finishes, the block gives a one-cycle completion pulse and a flag naming the descriptor that ended, so software knows which one to refill. When software marks a refreshed descriptor as the last one, that descriptor runs as a basic cycle and the channel goes idle after it. If the descriptor that would come next is not valid when the current one ends, the channel stops and reports a stall until software starts it again.

Top module: `dseq_top`

## Requirements
- R1: After a synchronous reset, run_o, done_o, done_alt_o, stall_o and sel_alt_o are all 0.
- R2: A start pulse with cycle type 0 (off) is ignored. The channel stays idle and run_o stays 0, even while requests arrive.
- R3: In basic (cycle type 1) and ping-pong (cycle type 3) mode, run_o rises on the cycle after a request is sampled while the channel waits. It falls on the cycle after a unit_done_i. The next unit then waits for a new request.
- R4: In auto-request mode (cycle type 2), a single request starts the run. run_o stays high across unit boundaries without further requests until the descriptor completes.
- R5: A completion (unit_done_i and desc_done_i together while running) gives done_o high for exactly one cycle, on the next cycle. In that same cycle done_alt_o shows the descriptor that finished (0 primary, 1 alternate).
- R6: In basic and auto modes, completion returns the channel to idle with sel_alt_o unchanged.
- R7: In ping-pong mode, completion of a descriptor whose last bit is clear moves sel_alt_o to the other descriptor on the next cycle. The channel then waits for a request.
- R8: In ping-pong mode, completion of a descriptor whose desc_last_i bit is set (bit 0 primary, bit 1 alternate) ends the sequence: the channel goes idle and requests have no effect.
- R9: In ping-pong mode, if the next descriptor's desc_vld_i bit is clear at completion, stall_o rises with run_o low. Both hold until a new start.
- R10: A start whose chosen descriptor's valid bit is clear goes straight to the stalled state.
- R11: start_i is ignored while the channel is waiting or running.
- R12: start_alt_i picks the first descriptor: 0 primary, 1 alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the channel |
| start_alt_i | input | 1 | First descriptor: 0 primary, 1 alternate |
| mode_i | input | 2 | Cycle type: 0 off, 1 basic, 2 auto, 3 ping-pong |
| req_i | input | 1 | Peripheral request |
| desc_vld_i | input | 2 | Descriptor valid bits, bit 0 primary, bit 1 alternate |
| desc_last_i | input | 2 | Descriptor last bits, bit 0 primary, bit 1 alternate |
| unit_done_i | input | 1 | Address generator ended an arbitration unit |
| desc_done_i | input | 1 | With unit_done_i: that unit ended the descriptor |
| run_o | output | 1 | Address generator may transfer |
| sel_alt_o | output | 1 | Active descriptor: 0 primary, 1 alternate |
| done_o | output | 1 | One-cycle completion pulse |
| done_alt_o | output | 1 | Descriptor that completed |
| stall_o | output | 1 | Channel stopped on an invalid descriptor |

## Verification
Basic runs with requests spaced far apart show whether each unit really waits for its own request. An auto run with no request after the first shows whether one request carries the whole descriptor. Ping-pong runs with both descriptors valid show the alternation and the completion flag. Runs with the last bit set or a valid bit cleared show the clean end and the stall. A start pulse during an active run, and a start with cycle type off, show that start is gated.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int MODE_W = 2;
  localparam int NDESC  = 2;

  typedef enum logic [MODE_W-1:0] {
    CYC_OFF      = 2'd0,
    CYC_BASIC    = 2'd1,
    CYC_AUTO     = 2'd2,
    CYC_PINGPONG = 2'd3
  } cyc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_XFER  = 2'd2,
    ST_STALL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dseq_launch.sv
module dseq_launch
  import dseq_pkg::*;
(
  input  logic              start_i,
  input  logic              idle_i,
  input  logic              start_alt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NDESC-1:0]  desc_vld_i,
  output logic              launch_ok_o,
  output logic              launch_bad_o
);
  logic accept;

  // a start counts only from idle or stall and with a real cycle type
  assign accept       = start_i && idle_i && (mode_i != CYC_OFF);
  assign launch_ok_o  = accept && desc_vld_i[start_alt_i];
  assign launch_bad_o = accept && !desc_vld_i[start_alt_i];
endmodule

// File: rtl/dseq_next.sv
module dseq_next
  import dseq_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              cur_alt_i,
  input  logic [NDESC-1:0]  desc_vld_i,
  input  logic [NDESC-1:0]  desc_last_i,
  output logic              chain_o,
  output logic              next_alt_o,
  output logic              next_ok_o
);
  // a descriptor flagged last behaves as basic: no hand-over
  assign chain_o    = (mode_i == CYC_PINGPONG) && !desc_last_i[cur_alt_i];
  assign next_alt_o = ~cur_alt_i;
  assign next_ok_o  = desc_vld_i[next_alt_o];
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              start_alt_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              req_i,
  input  logic [NDESC-1:0]  desc_vld_i,
  input  logic [NDESC-1:0]  desc_last_i,
  input  logic              unit_done_i,
  input  logic              desc_done_i,
  output logic              run_o,
  output logic              sel_alt_o,
  output logic              done_o,
  output logic              done_alt_o,
  output logic              stall_o
);
  seq_state_e state_q;
  logic       sel_q, done_q, done_alt_q;
  logic       idle_w, launch_ok, launch_bad;
  logic       chain, next_alt, next_ok;

  assign idle_w = (state_q == ST_IDLE) || (state_q == ST_STALL);

  dseq_launch u_launch (
    .start_i     (start_i),
    .idle_i      (idle_w),
    .start_alt_i (start_alt_i),
    .mode_i      (mode_i),
    .desc_vld_i  (desc_vld_i),
    .launch_ok_o (launch_ok),
    .launch_bad_o(launch_bad)
  );

  dseq_next u_next (
    .mode_i     (mode_i),
    .cur_alt_i  (sel_q),
    .desc_vld_i (desc_vld_i),
    .desc_last_i(desc_last_i),
    .chain_o    (chain),
    .next_alt_o (next_alt),
    .next_ok_o  (next_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sel_q      <= 1'b0;
      done_q     <= 1'b0;
      done_alt_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_STALL: begin
          if (launch_ok) begin
            sel_q   <= start_alt_i;
            state_q <= ST_WAIT;
          end else if (launch_bad) begin
            sel_q   <= start_alt_i;
            state_q <= ST_STALL;
          end
        end
        ST_WAIT: begin
          if (req_i) state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (unit_done_i) begin
            if (desc_done_i) begin
              done_q     <= 1'b1;
              done_alt_q <= sel_q;
              if (chain) begin
                sel_q   <= next_alt;
                state_q <= next_ok ? ST_WAIT : ST_STALL;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (mode_i != CYC_AUTO) begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o      = (state_q == ST_XFER);
  assign stall_o    = (state_q == ST_STALL);
  assign sel_alt_o  = sel_q;
  assign done_o     = done_q;
  assign done_alt_o = done_alt_q;
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker
  import dseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode_i,
  input logic              unit_done_i,
  input logic              desc_done_i,
  input logic              run_o,
  input logic              sel_alt_o,
  input logic              done_o,
  input logic              done_alt_o,
  input logic              stall_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
  AST_DONE_NAMES_SEL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (done_alt_o == $past(sel_alt_o))); // R5
  AST_STALL_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> !run_o); // R9
  AST_AUTO_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (run_o && mode_i == CYC_AUTO && unit_done_i && !desc_done_i) |=> run_o); // R4
  AST_UNIT_DROPS_RUN: assert property (@(posedge clk) disable iff (rst)
    (run_o && mode_i != CYC_AUTO && unit_done_i) |=> !run_o); // R3
  AST_PLAIN_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(mode_i) != CYC_PINGPONG) |-> (sel_alt_o == done_alt_o)); // R6
endmodule

bind dseq_top dseq_checker u_dseq_checker (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .unit_done_i(unit_done_i),
  .desc_done_i(desc_done_i),
  .run_o      (run_o),
  .sel_alt_o  (sel_alt_o),
  .done_o     (done_o),
  .done_alt_o (done_alt_o),
  .stall_o    (stall_o)
);

// File: tb/dseq_top_bench.sv
module dseq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 0, start_alt_i = 0, req_i = 0;
  logic [1:0] mode_i = 0, desc_vld_i = 0, desc_last_i = 0;
  logic       unit_done_i = 0, desc_done_i = 0;
  logic       run_o, sel_alt_o, done_o, done_alt_o, stall_o;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    ended = 0;

  always #4 clk = ~clk; // 125 MHz

  dseq_top u_dseq_top (
    .clk(clk), .rst(rst), .start_i(start_i), .start_alt_i(start_alt_i),
    .mode_i(mode_i), .req_i(req_i), .desc_vld_i(desc_vld_i),
    .desc_last_i(desc_last_i), .unit_done_i(unit_done_i),
    .desc_done_i(desc_done_i), .run_o(run_o), .sel_alt_o(sel_alt_o),
    .done_o(done_o), .done_alt_o(done_alt_o), .stall_o(stall_o)
  );

  // behavioural reference: phase 0 idle, 1 waiting, 2 moving, 3 stalled
  int m_ph;
  bit m_sel, m_done, m_dalt;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_sel = 0; m_done = 0; m_dalt = 0;
    end else begin
      m_done = 0;
      if (m_ph == 0 || m_ph == 3) begin
        if (start_i && mode_i != 0) begin
          m_sel = start_alt_i;
          m_ph  = desc_vld_i[start_alt_i] ? 1 : 3;
        end
      end else if (m_ph == 1) begin
        if (req_i) m_ph = 2;
      end else if (unit_done_i) begin
        if (desc_done_i) begin
          m_done = 1; m_dalt = m_sel;
          if (mode_i == 3 && !desc_last_i[m_sel]) begin
            m_sel = ~m_sel;
            m_ph  = desc_vld_i[m_sel] ? 1 : 3;
          end else m_ph = 0;
        end else if (mode_i != 2) m_ph = 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk({cur_req, " run_o"},      run_o,      (m_ph == 2));
      chk({cur_req, " stall_o"},    stall_o,    (m_ph == 3));
      chk({cur_req, " sel_alt_o"},  sel_alt_o,  m_sel);
      chk({cur_req, " done_o"},     done_o,     m_done);
      chk({cur_req, " done_alt_o"}, done_alt_o, m_dalt);
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start(bit alt);
    start_i = 1; start_alt_i = alt; cyc(); start_i = 0; start_alt_i = 0;
  endtask
  task automatic do_req();
    req_i = 1; cyc(); req_i = 0;
  endtask
  task automatic do_unit(bit fin);
    unit_done_i = 1; desc_done_i = fin; cyc(); unit_done_i = 0; desc_done_i = 0;
  endtask

  initial begin
    cyc(4); rst = 0; cyc();
    cur_req = "R1";
    chk("R1 run", run_o, 0); chk("R1 done", done_o, 0); chk("R1 stall", stall_o, 0);
    chk("R1 sel", sel_alt_o, 0); chk("R1 done_alt", done_alt_o, 0);

    cur_req = "R2";
    mode_i = 0; desc_vld_i = 2'b11; do_start(0); do_req(); do_req();
    chk("R2 run", run_o, 0);

    cur_req = "R3";
    mode_i = 1; do_start(0); cyc(3);
    chk("R3 no req no run", run_o, 0);
    do_req(); chk("R3 run after req", run_o, 1);
    do_unit(0); chk("R3 run drops", run_o, 0);
    cyc(5); chk("R3 waits for req", run_o, 0);
    do_req(); chk("R3 second unit", run_o, 1);
    cur_req = "R5";
    do_unit(1); chk("R5 done pulse", done_o, 1); chk("R5 primary flag", done_alt_o, 0);
    cyc(); chk("R5 single pulse", done_o, 0);
    cur_req = "R6";
    chk("R6 idle", run_o, 0); chk("R6 sel kept", sel_alt_o, 0);

    cur_req = "R12";
    do_start(1); chk("R12 alt chosen", sel_alt_o, 1);
    do_req(); do_unit(1); chk("R12 alt flag", done_alt_o, 1);
    cyc(); chk("R6 sel kept alt", sel_alt_o, 1);

    cur_req = "R4";
    mode_i = 2; do_start(0); do_req();
    for (int u = 0; u < 4; u++) begin
      do_unit(0); chk("R4 run held", run_o, 1);
      cyc(2);
    end
    cur_req = "R11";
    do_start(1); chk("R11 start ignored sel", sel_alt_o, 0); chk("R11 still running", run_o, 1);
    cur_req = "R4";
    do_unit(1); chk("R4 done", done_o, 1); cyc();

    cur_req = "R7";
    mode_i = 3; desc_vld_i = 2'b11; desc_last_i = 2'b00;
    do_start(0); do_req(); do_unit(1);
    chk("R7 flag primary", done_alt_o, 0); chk("R7 switch to alt", sel_alt_o, 1);
    chk("R7 waits", run_o, 0);
    do_req(); do_unit(1);
    chk("R7 flag alt", done_alt_o, 1); chk("R7 switch back", sel_alt_o, 0);
    cur_req = "R8";
    desc_last_i = 2'b01; do_req(); do_unit(1);
    chk("R8 done", done_o, 1); cyc();
    do_req(); chk("R8 ended idle", run_o, 0); chk("R8 no stall", stall_o, 0);
    desc_last_i = 2'b00;

    cur_req = "R9";
    desc_vld_i = 2'b01; do_start(0); do_req(); do_unit(1);
    chk("R9 stall", stall_o, 1); chk("R9 no run", run_o, 0);
    desc_vld_i = 2'b11; do_req(); cyc(3);
    chk("R9 stall held", stall_o, 1);
    do_start(1); chk("R9 cleared by start", stall_o, 0);
    mode_i = 1; do_req(); do_unit(1); cyc();

    cur_req = "R10";
    desc_vld_i = 2'b00; do_start(0);
    chk("R10 stall on start", stall_o, 1);
    do_req(); chk("R10 no run", run_o, 0);
    desc_vld_i = 2'b11; do_start(0); do_req(); do_unit(1); cyc(2);

    finish_run();
  end
endmodule